// File: doc/BRIEF.md
# Debug Data-Port Block Command Engine

This block sits on the target side of a debug link, behind one byte-wide data register. A debug host drives every operation through that register. It first writes a command byte, then reads back a status byte. After a good status it writes a start address and a byte count. It then moves that many data bytes in or out of one of two internal spaces, a small register window or a byte RAM. Two flags pace the host. The busy flag shows that the engine is still taking in the byte just written. The valid flag shows that a byte is waiting to be read.

Four command codes are served: 0x09 reads the register space, 0x0A writes it, 0x0B reads the RAM and 0x0C writes it. Flash commands (0x03, 0x06, 0x07, 0x08) and every other code are decoded and refused with an error status. The engine then drops back to waiting for a command.

Top module: `dbgp_engine`

## Requirements
- R1: After reset, `in_busy` and `out_valid` are low and `rd_data` is 0x00.
- R2: When a command byte is accepted, `in_busy` is high for exactly the next cycle. After that, `out_valid` rises with `rd_data` holding the status. The codes 0x09, 0x0A, 0x0B and 0x0C give status 0x0D.
- R3: Any other command code, including the flash codes 0x03, 0x06, 0x07 and 0x08, gives status 0xEE. Once that status is read, the next written byte is taken as a new command.
- R4: After a 0x0D status has been read, the next written byte is the start address and the one after it is the byte count. Each is acknowledged by a single cycle of `in_busy`.
- R5: In a read command (0x09 or 0x0B), each data byte is presented with `out_valid`, taken from successive addresses starting at the start address. Each byte is consumed by a pulse of `rd_en`. After the last byte, the engine waits for a command.
- R6: In a write command (0x0A or 0x0C), each written data byte is stored at the next successive address and acknowledged by one cycle of `in_busy`. After the last byte, the engine waits for a command.
- R7: A byte count of 0 moves 256 bytes, and the block address wraps from 0xFF to 0x00.
- R8: The register space holds storage only at addresses 0x20 to 0x33. Reads of any other register address return 0x00, and writes to them are dropped. The RAM holds all 256 addresses.
- R9: A write while `out_valid` is high is ignored, and the pending byte is kept. A `rd_en` while `out_valid` is low is ignored, and `rd_data` is left unchanged.
- R10: The register space and the RAM are separate, so a register block write leaves the RAM bytes at the same addresses unchanged.
- R11: `in_busy` and `out_valid` are never high together, and `in_busy` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe to the data register |
| wr_data | input | 8 | Byte written by the host |
| rd_en | input | 1 | Host read strobe of the data register |
| rd_data | output | 8 | Status or data byte presented to the host |
| in_busy | output | 1 | Engine is consuming the byte just written |
| out_valid | output | 1 | A byte is waiting in `rd_data` |

## Verification
Every command code of interest is sent, each one compared against the status it should produce. This separates the four served codes from the flash codes and from unused codes. Block transfers run with a short count at a mid-range address, with count 0 starting near the top of the address space to exercise the 256-byte length and the wrap, and with a register-space block that straddles both edges of the 0x20 to 0x33 window, so stored bytes can be told apart from dropped ones. A RAM read after the register write shows that the two spaces do not alias. Stray writes while a byte is pending, and stray reads while nothing is pending, show that the protocol state and the data are left untouched.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  localparam int DW = 8;

  localparam logic [DW-1:0] CMD_REG_RD = 8'h09;
  localparam logic [DW-1:0] CMD_REG_WR = 8'h0A;
  localparam logic [DW-1:0] CMD_RAM_RD = 8'h0B;
  localparam logic [DW-1:0] CMD_RAM_WR = 8'h0C;

  localparam logic [DW-1:0] STAT_OK  = 8'h0D;
  localparam logic [DW-1:0] STAT_BAD = 8'hEE;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DECODE,
    ST_STATUS,
    ST_WAIT_ADDR,
    ST_TAKE_ADDR,
    ST_WAIT_CNT,
    ST_TAKE_CNT,
    ST_FETCH,
    ST_PRESENT,
    ST_WAIT_DATA,
    ST_STORE
  } eng_state_t;

  typedef struct packed {
    logic ok;
    logic is_read;
    logic is_ram;
  } cmd_info_t;

  // Number of bytes moved for a count byte: zero stands for a full 256.
  function automatic logic [DW:0] block_len(input logic [DW-1:0] cnt);
    block_len = (cnt == '0) ? {1'b1, {DW{1'b0}}} : {1'b0, cnt};
  endfunction

  // Block address advance, wrapping modulo 2**DW.
  function automatic logic [DW-1:0] next_addr(input logic [DW-1:0] a);
    next_addr = a + 1'b1;
  endfunction

endpackage

// File: rtl/dbgp_decode.sv
module dbgp_decode
  import dbgp_pkg::*;
(
  input  logic [DW-1:0] code,
  output cmd_info_t     info
);
  always_comb begin
    info = '0;
    unique case (code)
      CMD_REG_RD: info = '{ok: 1'b1, is_read: 1'b1, is_ram: 1'b0};
      CMD_REG_WR: info = '{ok: 1'b1, is_read: 1'b0, is_ram: 1'b0};
      CMD_RAM_RD: info = '{ok: 1'b1, is_read: 1'b1, is_ram: 1'b1};
      CMD_RAM_WR: info = '{ok: 1'b1, is_read: 1'b0, is_ram: 1'b1};
      default:    info = '0;
    endcase
  end
endmodule

// File: rtl/dbgp_regfile.sv
module dbgp_regfile
  import dbgp_pkg::*;
#(
  parameter int WIN_LO = 32'h20,
  parameter int WIN_HI = 32'h33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int NREG = WIN_HI - WIN_LO + 1;

  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MY_ADDR = DW'(WIN_LO + i);
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (we && addr == MY_ADDR)
        regs[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == DW'(WIN_LO + i))
        rdata = regs[i];
  end
endmodule

// File: rtl/dbgp_ram.sv
module dbgp_ram
  import dbgp_pkg::*;
(
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << DW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dbgp_engine.sv
module dbgp_engine
  import dbgp_pkg::*;
#(
  parameter int REG_WIN_LO = 32'h20,
  parameter int REG_WIN_HI = 32'h33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          in_busy,
  output logic          out_valid
);
  eng_state_t    state_q;
  cmd_info_t     dec_info;
  cmd_info_t     info_q;
  logic [DW-1:0] addr_q;
  logic [DW:0]   remain_q;
  logic [DW-1:0] rd_data_q;
  logic [DW-1:0] wbyte_q;

  // Named internal events for the checker.
  logic wr_accept;
  logic rd_accept;
  logic last_byte;
  logic mem_we;
  logic reg_we;
  logic ram_we;
  logic [DW-1:0] reg_rdata;
  logic [DW-1:0] ram_rdata;
  logic [DW-1:0] mem_rdata;

  dbgp_decode dec_i (
    .code (wr_data),
    .info (dec_info)
  );

  assign in_busy   = (state_q == ST_DECODE)   || (state_q == ST_TAKE_ADDR) ||
                     (state_q == ST_TAKE_CNT) || (state_q == ST_STORE);
  assign out_valid = (state_q == ST_STATUS)   || (state_q == ST_PRESENT);

  assign wr_accept = wr_en && ((state_q == ST_IDLE)     || (state_q == ST_WAIT_ADDR) ||
                               (state_q == ST_WAIT_CNT) || (state_q == ST_WAIT_DATA));
  assign rd_accept = rd_en && out_valid;
  assign last_byte = (remain_q == {{DW{1'b0}}, 1'b1});

  assign mem_we    = (state_q == ST_STORE);
  assign reg_we    = mem_we && !info_q.is_ram;
  assign ram_we    = mem_we &&  info_q.is_ram;
  assign mem_rdata = info_q.is_ram ? ram_rdata : reg_rdata;
  assign rd_data   = rd_data_q;

  dbgp_regfile #(
    .WIN_LO (REG_WIN_LO),
    .WIN_HI (REG_WIN_HI)
  ) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (addr_q),
    .wdata (wbyte_q),
    .rdata (reg_rdata)
  );

  dbgp_ram ram_i (
    .clk   (clk),
    .we    (ram_we),
    .addr  (addr_q),
    .wdata (wbyte_q),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      info_q    <= '0;
      addr_q    <= '0;
      remain_q  <= '0;
      rd_data_q <= '0;
      wbyte_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_accept) begin
          info_q  <= dec_info;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          rd_data_q <= info_q.ok ? STAT_OK : STAT_BAD;
          state_q   <= ST_STATUS;
        end
        ST_STATUS: if (rd_accept)
          state_q <= info_q.ok ? ST_WAIT_ADDR : ST_IDLE;
        ST_WAIT_ADDR: if (wr_accept) begin
          addr_q  <= wr_data;
          state_q <= ST_TAKE_ADDR;
        end
        ST_TAKE_ADDR: state_q <= ST_WAIT_CNT;
        ST_WAIT_CNT: if (wr_accept) begin
          remain_q <= block_len(wr_data);
          state_q  <= ST_TAKE_CNT;
        end
        ST_TAKE_CNT: state_q <= info_q.is_read ? ST_FETCH : ST_WAIT_DATA;
        ST_FETCH: begin
          rd_data_q <= mem_rdata;
          state_q   <= ST_PRESENT;
        end
        ST_PRESENT: if (rd_accept) begin
          addr_q   <= next_addr(addr_q);
          remain_q <= remain_q - 1'b1;
          state_q  <= last_byte ? ST_IDLE : ST_FETCH;
        end
        ST_WAIT_DATA: if (wr_accept) begin
          wbyte_q <= wr_data;
          state_q <= ST_STORE;
        end
        ST_STORE: begin
          addr_q   <= next_addr(addr_q);
          remain_q <= remain_q - 1'b1;
          state_q  <= last_byte ? ST_IDLE : ST_WAIT_DATA;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbgp_engine_chk.sv
module dbgp_engine_chk
  import dbgp_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          in_busy,
  input logic          out_valid,
  input logic          wr_accept,
  input logic          rd_accept
);
  // R11: the two flags never overlap
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_busy && out_valid));

  // R11: busy lasts a single cycle
  assert_busy_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_busy |=> !in_busy);

  // R2: an accepted byte is acknowledged by busy on the next cycle
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> in_busy);

  // R5: a consumed byte withdraws the valid flag
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> !out_valid);

  // R9: a pending byte is held until it is read
  assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !rd_en) |=> (out_valid && $stable(rd_data)));

  // R9: a read with nothing pending leaves the output byte alone
  assert_stray_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_busy && rd_en) |=> $stable(rd_data));
endmodule

bind dbgp_engine dbgp_engine_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .in_busy   (in_busy),
  .out_valid (out_valid),
  .wr_accept (wr_accept),
  .rd_accept (rd_accept)
);

// File: tb/dbgp_engine_tb.sv
module dbgp_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       in_busy;
  logic       out_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  dbgp_engine dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .rd_en (rd_en), .rd_data (rd_data), .in_busy (in_busy), .out_valid (out_valid)
  );

  // Bad-command table: {code, expected status}
  localparam logic [15:0] BAD_TAB [9] = '{
    16'h03EE, 16'h06EE, 16'h07EE, 16'h08EE, 16'h00EE,
    16'h0DEE, 16'hFFEE, 16'h01EE, 16'h02EE
  };

  function automatic logic [7:0] wrap_pat(input logic [7:0] a);
    logic [7:0] idx;
    idx = a - 8'hF8;
    return idx ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] b, input string req);
    int n;
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
    check(req, {7'd0, in_busy}, 8'h01);
    n = 0;
    while (in_busy && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic host_read(output logic [7:0] b, input string req);
    int n;
    n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    if (!out_valid) begin
      checks++; fails++;
      $display("FAIL %s: actual no-valid expected valid", req);
    end
    b = rd_data;
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic open_block(input logic [7:0] cmd, input logic [7:0] a, input logic [7:0] c);
    logic [7:0] s;
    host_write(cmd, "R2");
    host_read(s, "R2");
    check("R2", s, 8'h0D);
    host_write(a, "R4");
    host_write(c, "R4");
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {6'd0, in_busy, out_valid}, 8'h00);
    check("R1", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 table of refused codes; each next entry proves return to idle
    for (int i = 0; i < 9; i++) begin
      host_write(BAD_TAB[i][15:8], "R3");
      host_read(s, "R3");
      check("R3", s, BAD_TAB[i][7:0]);
    end

    // R6/R5 short RAM block at 0x10
    open_block(8'h0C, 8'h10, 8'd5);
    for (int i = 0; i < 5; i++) host_write(8'hA0 + 8'(i), "R6");
    open_block(8'h0B, 8'h10, 8'd5);
    for (int i = 0; i < 5; i++) begin
      host_read(s, "R5");
      check("R5", s, 8'hA0 + 8'(i));
    end
    check("R5", {7'd0, out_valid}, 8'h00);

    // R9: write while status pending is ignored; stray read while nothing pending
    host_write(8'h0B, "R2");
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h55;
    @(negedge clk); wr_en = 1'b0;
    check("R9", {6'd0, in_busy, out_valid}, 8'h01);
    host_read(s, "R9");
    check("R9", s, 8'h0D);
    host_write(8'h12, "R4");
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R9", rd_data, 8'h0D);
    check("R9", {7'd0, out_valid}, 8'h00);
    host_write(8'd2, "R4");
    host_read(s, "R9"); check("R9", s, 8'hA2);
    host_read(s, "R9"); check("R9", s, 8'hA3);

    // R7: count 0 means 256 bytes, wrapping from 0xF8
    open_block(8'h0C, 8'hF8, 8'h00);
    for (int i = 0; i < 256; i++) host_write(8'(i) ^ 8'h5A, "R7");
    open_block(8'h0B, 8'hF8, 8'h00);
    for (int i = 0; i < 256; i++) begin
      host_read(s, "R7");
      check("R7", s, wrap_pat(8'hF8 + 8'(i)));
    end
    // engine must be idle: a refused code gets its error status
    host_write(8'h06, "R7");
    host_read(s, "R7");
    check("R7", s, 8'hEE);

    // R8: register block across the window edges 0x1E..0x35
    open_block(8'h0A, 8'h1E, 8'd24);
    for (int i = 0; i < 24; i++) host_write(8'h80 + 8'(i), "R8");
    open_block(8'h09, 8'h1E, 8'd24);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a;
      a = 8'h1E + 8'(i);
      host_read(s, "R8");
      check("R8", s, (a >= 8'h20 && a <= 8'h33) ? 8'h80 + 8'(i) : 8'h00);
    end

    // R10: RAM at the same addresses is untouched
    open_block(8'h0B, 8'h20, 8'd4);
    for (int i = 0; i < 4; i++) begin
      host_read(s, "R10");
      check("R10", s, wrap_pat(8'h20 + 8'(i)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule